// File: doc/BRIEF.md
# Indirect Interrupt Routing Register Window

This block sits on a memory-mapped bus and gives software access to an interrupt router's routing table through a narrow opening. There are only two registers in the bus map. The first is an 8-bit index register. The second is a 32-bit data window that reaches whichever internal register the index names. That internal space holds three things:

- a version word;
- a 4-bit identification field with a read-only mirror;
- one 64-bit routing entry per interrupt pin. Each entry appears as two 32-bit halves at consecutive indices.

A third aligned bus offset takes end-of-interrupt writes.

The block stores the routing table. It tells the neighbouring delivery logic about changes that need action:

- a pin's mask bit flipping;
- a level-triggered pin that is still asserted when its entry is rewritten;
- an end-of-interrupt for a given vector.

The delivery logic sets an entry's remote-pending bit through a dedicated input. Two things clear that bit: a matching end-of-interrupt, or a bus write to the entry's low half.

Top module: `irq_win_regs`

## Requirements
- R1: A write at bus offset 0x00 stores the low 8 bits of the data as the index. A read at offset 0x00 returns the index, zero-extended.
- R2: With the index at 0x00, a window read (offset 0x10) returns the pin count minus one in bits 23:16 and the version code in bits 7:0, with all other bits zero. Window writes at this index change nothing.
- R3: With the index at 0x01, a window write stores data bits 27:24 as the ID, and a read returns the ID in bits 27:24 with the other bits zero. Index 0x02 reads the same ID in the same place, and its writes are ignored.
- R4: Index 0x10+2n reaches bits 31:0 of entry n, and index 0x11+2n reaches bits 63:32. Writes store the data and reads return it (except bit 14, see R6).
- R5: For a routing index whose entry number is at or beyond the pin count, reads return 0xFFFFFFFF and writes change no entry.
- R6: Bit 14 of an entry is its remote-pending flag. The rirr_set input sets it. A bus write to the low half clears it whatever the data's bit 14 holds. A write to the high half leaves it unchanged.
- R7: When a window write flips an entry's mask bit (bit 16), mask_evt pulses for one cycle in the next cycle. mask_evt_pin carries the pin and mask_evt_val carries the new mask. A write that leaves the mask unchanged gives no pulse.
- R8: After any window write to an entry whose trigger bit (bit 15, 1 = level) is 1 once the write completes, redeliver pulses in the next cycle with redeliver_pin set, provided the pin's pin_level input is high at the write. Otherwise it does not pulse.
- R9: Reset sets every entry to mask=1 with all other bits zero, clears the index and the ID, and leaves every pulse output low.
- R10: A write at offset 0x40 pulses eoi_valid in the next cycle with eoi_vector equal to data bits 7:0. It also clears the remote-pending flag of every level-triggered entry whose vector (bits 7:0) matches. Edge-triggered entries keep their flag.
- R11: A bus address whose low 4 bits are non-zero, an aligned address other than 0x00/0x10/0x40, or an index in 0x03..0x0F reads zero, and writes to any of them change nothing.
- R12: bus_rvalid is high exactly one cycle after bus_rd, and bus_rdata holds the read result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | ADDR_W | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| pin_level | input | NPINS | Current asserted state of each interrupt pin |
| rirr_set | input | NPINS | Set remote-pending flag of each flagged pin |
| mask_evt | output | 1 | Mask bit of an entry changed |
| mask_evt_pin | output | PIN_W | Pin whose mask changed |
| mask_evt_val | output | 1 | New mask value |
| redeliver | output | 1 | Request delivery of a still-asserted level pin |
| redeliver_pin | output | PIN_W | Pin to deliver |
| eoi_valid | output | 1 | End-of-interrupt received |
| eoi_vector | output | 8 | Vector of the end-of-interrupt |

## Verification
A corrupted index register sends every later window access to the wrong place. The error appears on the very next window read as the wrong entry half or a wrong all-ones pattern. A remote-pending flag that was not cleared, or was set wrongly, shows up as bit 14 on the next readback of that entry's low half. Wrong mask bookkeeping appears one cycle after the offending write, as a missing or extra mask_evt pulse. The bench therefore reads back after each mutating step and samples the event outputs in the cycle right after each write.

// File: rtl/irq_win_pkg.sv
package irq_win_pkg;

    localparam int unsigned BUS_W   = 32;
    localparam int unsigned OFS_SEL = 'h00;
    localparam int unsigned OFS_WIN = 'h10;
    localparam int unsigned OFS_EOI = 'h40;

    localparam logic [7:0] IDX_VER   = 8'h00;
    localparam logic [7:0] IDX_ID    = 8'h01;
    localparam logic [7:0] IDX_ARB   = 8'h02;
    localparam logic [7:0] IDX_REDIR = 8'h10;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_SEL,
        ACC_WIN,
        ACC_EOI
    } acc_kind_e;

    // one routing entry; bit positions matter to the delivery logic
    typedef struct packed {
        logic [7:0]  dest;
        logic [38:0] rsvd;
        logic        mask;   // bit 16
        logic        trig;   // bit 15, 1 = level
        logic        rirr;   // bit 14
        logic        pol;
        logic        busy;
        logic        dmode;
        logic [2:0]  dlv;
        logic [7:0]  vec;    // bits 7:0
    } redir_entry_t;

    function automatic redir_entry_t entry_reset();
        redir_entry_t e;
        e      = '0;
        e.mask = 1'b1;
        return e;
    endfunction

    function automatic logic [BUS_W-1:0] version_word(int npins, logic [7:0] ver);
        return {8'h00, 8'(npins - 1), 8'h00, ver};
    endfunction

    function automatic logic [BUS_W-1:0] id_word(logic [3:0] id);
        return {4'h0, id, 24'h000000};
    endfunction

endpackage

// File: rtl/irq_win_decode.sv
module irq_win_decode
    import irq_win_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind
);

    always_comb begin
        if (addr[3:0] != 4'h0)
            kind = ACC_NONE;
        else if (addr == ADDR_W'(OFS_SEL))
            kind = ACC_SEL;
        else if (addr == ADDR_W'(OFS_WIN))
            kind = ACC_WIN;
        else if (addr == ADDR_W'(OFS_EOI))
            kind = ACC_EOI;
        else
            kind = ACC_NONE;
    end

endmodule

// File: rtl/irq_win_redir.sv
module irq_win_redir
    import irq_win_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int PIN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [6:0]       slot,
    input  logic             hi,
    input  logic [31:0]      wdata,
    input  logic [NPINS-1:0] pin_level,
    input  logic [NPINS-1:0] rirr_set,
    input  logic             eoi_we,
    input  logic [7:0]       eoi_vec,
    output logic [31:0]      rd_word,
    output logic             mask_evt,
    output logic [PIN_W-1:0] mask_evt_pin,
    output logic             mask_evt_val,
    output logic             redeliver,
    output logic [PIN_W-1:0] redeliver_pin
);

    redir_entry_t tbl_q [NPINS];
    redir_entry_t cur;
    logic         in_range;
    logic         pin_hit;
    logic         new_mask;
    logic         new_trig;
    logic         do_wr;

    assign in_range = (slot < 7'(NPINS));
    assign do_wr    = we && in_range;

    always_comb begin
        cur     = '0;
        pin_hit = 1'b0;
        for (int i = 0; i < NPINS; i++) begin
            if (7'(i) == slot) begin
                cur     = tbl_q[i];
                pin_hit = pin_level[i];
            end
        end
    end

    assign rd_word  = !in_range ? '1 : (hi ? cur[63:32] : cur[31:0]);
    assign new_mask = hi ? cur.mask : wdata[16];
    assign new_trig = hi ? cur.trig : wdata[15];

    for (genvar g = 0; g < NPINS; g++) begin : g_entry
        redir_entry_t ent_q;
        redir_entry_t ent_d;

        always_comb begin
            ent_d = ent_q;
            if (eoi_we && ent_d.trig && (ent_d.vec == eoi_vec))
                ent_d.rirr = 1'b0;
            if (rirr_set[g])
                ent_d.rirr = 1'b1;
            if (do_wr && (slot == 7'(g))) begin
                if (hi) begin
                    ent_d = {wdata, ent_d[31:0]};
                end else begin
                    ent_d      = {ent_d[63:32], wdata};
                    ent_d.rirr = 1'b0;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst)
                ent_q <= entry_reset();
            else
                ent_q <= ent_d;
        end

        assign tbl_q[g] = ent_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_evt      <= 1'b0;
            mask_evt_pin  <= '0;
            mask_evt_val  <= 1'b0;
            redeliver     <= 1'b0;
            redeliver_pin <= '0;
        end else begin
            mask_evt      <= do_wr && (new_mask != cur.mask);
            mask_evt_pin  <= slot[PIN_W-1:0];
            mask_evt_val  <= new_mask;
            redeliver     <= do_wr && new_trig && pin_hit;
            redeliver_pin <= slot[PIN_W-1:0];
        end
    end

endmodule

// File: rtl/irq_win_regs.sv
module irq_win_regs
    import irq_win_pkg::*;
#(
    parameter int          NPINS   = 24,
    parameter logic [7:0]  VERSION = 8'h20,
    parameter int          ADDR_W  = 8,
    localparam int         PIN_W   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic [NPINS-1:0]  pin_level,
    input  logic [NPINS-1:0]  rirr_set,
    output logic              mask_evt,
    output logic [PIN_W-1:0]  mask_evt_pin,
    output logic              mask_evt_val,
    output logic              redeliver,
    output logic [PIN_W-1:0]  redeliver_pin,
    output logic              eoi_valid,
    output logic [7:0]        eoi_vector
);

    acc_kind_e   kind;
    logic [7:0]  sel_q;
    logic [3:0]  id_q;
    logic        sel_redir;
    logic [7:0]  sel_off;
    logic [6:0]  slot;
    logic        tbl_we;
    logic        eoi_we;
    logic [31:0] tbl_word;
    logic [31:0] win_word;
    logic [31:0] rd_next;

    irq_win_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr (bus_addr),
        .kind (kind)
    );

    assign sel_redir = (sel_q >= IDX_REDIR);
    assign sel_off   = sel_q - IDX_REDIR;
    assign slot      = sel_off[7:1];
    assign tbl_we    = bus_wr && (kind == ACC_WIN) && sel_redir;
    assign eoi_we    = bus_wr && (kind == ACC_EOI);

    irq_win_redir #(.NPINS(NPINS), .PIN_W(PIN_W)) tbl_i (
        .clk           (clk),
        .rst           (rst),
        .we            (tbl_we),
        .slot          (slot),
        .hi            (sel_off[0]),
        .wdata         (bus_wdata),
        .pin_level     (pin_level),
        .rirr_set      (rirr_set),
        .eoi_we        (eoi_we),
        .eoi_vec       (bus_wdata[7:0]),
        .rd_word       (tbl_word),
        .mask_evt      (mask_evt),
        .mask_evt_pin  (mask_evt_pin),
        .mask_evt_val  (mask_evt_val),
        .redeliver     (redeliver),
        .redeliver_pin (redeliver_pin)
    );

    always_comb begin
        if (sel_redir)
            win_word = tbl_word;
        else if (sel_q == IDX_VER)
            win_word = version_word(NPINS, VERSION);
        else if ((sel_q == IDX_ID) || (sel_q == IDX_ARB))
            win_word = id_word(id_q);
        else
            win_word = '0;
    end

    always_comb begin
        case (kind)
            ACC_SEL: rd_next = {24'h0, sel_q};
            ACC_WIN: rd_next = win_word;
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q      <= '0;
            id_q       <= '0;
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            eoi_valid  <= 1'b0;
            eoi_vector <= '0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd)
                bus_rdata <= rd_next;
            if (bus_wr && (kind == ACC_SEL))
                sel_q <= bus_wdata[7:0];
            if (bus_wr && (kind == ACC_WIN) && (sel_q == IDX_ID))
                id_q <= bus_wdata[27:24];
            eoi_valid <= eoi_we;
            if (eoi_we)
                eoi_vector <= bus_wdata[7:0];
        end
    end

endmodule

// File: rtl/irq_win_chk.sv
module irq_win_chk
    import irq_win_pkg::*;
#(
    parameter int         NPINS   = 24,
    parameter logic [7:0] VERSION = 8'h20,
    parameter int         ADDR_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        wdata_lo,
    input logic [31:0]       bus_rdata,
    input logic              bus_rvalid,
    input logic [7:0]        sel_q,
    input logic              mask_evt,
    input logic              redeliver,
    input logic              eoi_valid,
    input logic [7:0]        eoi_vector
);

    a_r12_rvalid_follows_rd: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid);

    a_r12_no_stray_rvalid: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> !bus_rvalid);

    a_r1_index_written: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_SEL)) |=> (sel_q == $past(wdata_lo)));

    a_r2_version_read: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(OFS_WIN) && sel_q == IDX_VER)
        |=> (bus_rdata == {8'h00, 8'(NPINS - 1), 8'h00, VERSION}));

    a_r7_mask_evt_after_write: assert property (@(posedge clk) disable iff (rst)
        mask_evt |-> $past(bus_wr));

    a_r8_redeliver_after_write: assert property (@(posedge clk) disable iff (rst)
        redeliver |-> $past(bus_wr));

    a_r10_eoi_pulse: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_EOI))
        |=> (eoi_valid && eoi_vector == $past(wdata_lo)));

    a_r11_misaligned_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr[3:0] != 4'h0) |=> (bus_rdata == 32'h0));

endmodule

bind irq_win_regs irq_win_chk #(
    .NPINS   (NPINS),
    .VERSION (VERSION),
    .ADDR_W  (ADDR_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .wdata_lo   (bus_wdata[7:0]),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .sel_q      (sel_q),
    .mask_evt   (mask_evt),
    .redeliver  (redeliver),
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector)
);

// File: tb/irq_win_regs_tb.sv
module irq_win_regs_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NPINS      = 24;
    localparam int PIN_W      = 5;
    localparam int NVEC       = 32;

    // {op(1=read), addr[7:0], data/expected[31:0]}
    localparam logic [40:0] VEC [NVEC] = '{
        {1'b1, 8'h00, 32'h0000_0000},  // R9 index reset
        {1'b0, 8'h00, 32'hFFFF_FF01},  // R1
        {1'b1, 8'h00, 32'h0000_0001},  // R1
        {1'b0, 8'h10, 32'hA5C0_0000},  // R3 id write
        {1'b1, 8'h10, 32'h0500_0000},  // R3
        {1'b0, 8'h00, 32'h0000_0002},
        {1'b0, 8'h10, 32'h0F00_0000},  // R3 arb write ignored
        {1'b1, 8'h10, 32'h0500_0000},  // R3
        {1'b0, 8'h00, 32'h0000_0000},
        {1'b0, 8'h10, 32'hFFFF_FFFF},  // R2 write ignored
        {1'b1, 8'h10, 32'h0017_0020},  // R2
        {1'b0, 8'h00, 32'h0000_0010},
        {1'b1, 8'h10, 32'h0001_0000},  // R9 mask set
        {1'b0, 8'h10, 32'h0000_8031},
        {1'b1, 8'h10, 32'h0000_8031},  // R4 low half
        {1'b0, 8'h00, 32'h0000_0011},
        {1'b0, 8'h10, 32'hC300_0000},
        {1'b1, 8'h10, 32'hC300_0000},  // R4 high half
        {1'b0, 8'h00, 32'h0000_0040},
        {1'b1, 8'h10, 32'hFFFF_FFFF},  // R5
        {1'b0, 8'h10, 32'h0000_1234},
        {1'b1, 8'h10, 32'hFFFF_FFFF},  // R5
        {1'b0, 8'h00, 32'h0000_002F},
        {1'b1, 8'h10, 32'h0000_0000},  // R4 pin 15 high
        {1'b0, 8'h00, 32'h0000_003F},
        {1'b1, 8'h10, 32'h0000_0000},  // R5 pin 23 untouched
        {1'b0, 8'h00, 32'h0000_0005},
        {1'b1, 8'h10, 32'h0000_0000},  // R11 index gap
        {1'b1, 8'h08, 32'h0000_0000},  // R11 misaligned
        {1'b0, 8'h04, 32'h0000_0077},  // R11 misaligned write
        {1'b1, 8'h00, 32'h0000_0005},  // R11 index kept
        {1'b1, 8'h20, 32'h0000_0000}   // R11 unmapped offset
    };

    logic             clk = 1'b0;
    logic             rst;
    logic             bus_wr;
    logic             bus_rd;
    logic [7:0]       bus_addr;
    logic [31:0]      bus_wdata;
    logic [31:0]      bus_rdata;
    logic             bus_rvalid;
    logic [NPINS-1:0] pin_level;
    logic [NPINS-1:0] rirr_set;
    logic             mask_evt;
    logic [PIN_W-1:0] mask_evt_pin;
    logic             mask_evt_val;
    logic             redeliver;
    logic [PIN_W-1:0] redeliver_pin;
    logic             eoi_valid;
    logic [7:0]       eoi_vector;

    int total = 0;
    int bad   = 0;

    logic             c_mask_evt, c_mask_val, c_redeliver, c_eoi;
    logic [PIN_W-1:0] c_mask_pin, c_redeliver_pin;
    logic [7:0]       c_eoi_vec;
    logic [31:0]      rd_val;
    logic             rd_ok;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_win_regs dut_i (
        .clk           (clk),
        .rst           (rst),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .bus_rvalid    (bus_rvalid),
        .pin_level     (pin_level),
        .rirr_set      (rirr_set),
        .mask_evt      (mask_evt),
        .mask_evt_pin  (mask_evt_pin),
        .mask_evt_val  (mask_evt_val),
        .redeliver     (redeliver),
        .redeliver_pin (redeliver_pin),
        .eoi_valid     (eoi_valid),
        .eoi_vector    (eoi_vector)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        c_mask_evt = mask_evt; c_mask_pin = mask_evt_pin; c_mask_val = mask_evt_val;
        c_redeliver = redeliver; c_redeliver_pin = redeliver_pin;
        c_eoi = eoi_valid; c_eoi_vec = eoi_vector;
    endtask

    task automatic bus_read(input logic [7:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        rd_val = bus_rdata; rd_ok = bus_rvalid;
    endtask

    task automatic win_read(input logic [7:0] idx, input logic [31:0] exp, input string req);
        bus_write(8'h00, {24'h0, idx});
        bus_read(8'h10);
        check(rd_val == exp, req, rd_val, exp);
    endtask

    task automatic pulse_rirr(input int pin);
        @(negedge clk);
        rirr_set = '0; rirr_set[pin] = 1'b1;
        @(negedge clk);
        rirr_set = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        pin_level = '0; rirr_set = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R9: pulse outputs idle after reset
        check(!mask_evt && !redeliver && !eoi_valid && !bus_rvalid, "R9",
              {28'h0, mask_evt, redeliver, eoi_valid, bus_rvalid}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][40]) begin
                bus_read(VEC[i][39:32]);
                check(rd_val == VEC[i][31:0], $sformatf("vector %0d", i), rd_val, VEC[i][31:0]);
            end else begin
                bus_write(VEC[i][39:32], VEC[i][31:0]);
            end
        end

        // R12: read valid one cycle after strobe
        bus_read(8'h00);
        check(rd_ok == 1'b1, "R12", {31'h0, rd_ok}, 32'h1);
        @(negedge clk);
        check(bus_rvalid == 1'b0, "R12", {31'h0, bus_rvalid}, 32'h0);

        // R7: mask change events on pin 1
        bus_write(8'h00, 32'h12);
        bus_write(8'h10, 32'h0000_0040);
        check(c_mask_evt && c_mask_pin == 5'd1 && !c_mask_val, "R7",
              {c_mask_evt, 26'h0, c_mask_pin}, {1'b1, 26'h0, 5'd1});
        check(!c_eoi, "R10", {31'h0, c_eoi}, 32'h0);
        bus_write(8'h10, 32'h0000_0040);
        check(!c_mask_evt, "R7", {31'h0, c_mask_evt}, 32'h0);
        bus_write(8'h10, 32'h0001_0040);
        check(c_mask_evt && c_mask_val, "R7", {30'h0, c_mask_evt, c_mask_val}, 32'h3);

        // R8: redelivery of level pin 2
        pin_level = 24'h000004;
        bus_write(8'h00, 32'h14);
        bus_write(8'h10, 32'h0000_8050);
        check(c_redeliver && c_redeliver_pin == 5'd2, "R8",
              {c_redeliver, 26'h0, c_redeliver_pin}, {1'b1, 26'h0, 5'd2});
        bus_write(8'h10, 32'h0000_0050);
        check(!c_redeliver, "R8 edge", {31'h0, c_redeliver}, 32'h0);
        bus_write(8'h10, 32'h0000_8050);
        bus_write(8'h00, 32'h15);
        bus_write(8'h10, 32'h0000_0000);
        check(c_redeliver, "R8 high half", {31'h0, c_redeliver}, 32'h1);
        pin_level = '0;
        bus_write(8'h00, 32'h14);
        bus_write(8'h10, 32'h0000_8050);
        check(!c_redeliver, "R8 pin low", {31'h0, c_redeliver}, 32'h0);

        // R6: remote-pending flag handling
        pulse_rirr(2);
        win_read(8'h14, 32'h0000_C050, "R6 set");
        bus_write(8'h00, 32'h15);
        bus_write(8'h10, 32'h0100_0000);
        win_read(8'h14, 32'h0000_C050, "R6 high keeps");
        bus_write(8'h00, 32'h14);
        bus_write(8'h10, 32'h0000_C050);
        win_read(8'h14, 32'h0000_8050, "R6 low clears");

        // R10: end of interrupt
        pulse_rirr(2);
        bus_write(8'h00, 32'h16);
        bus_write(8'h10, 32'h0000_0050);
        pulse_rirr(3);
        bus_write(8'h40, 32'hFFFF_FF50);
        check(c_eoi && c_eoi_vec == 8'h50, "R10 pulse", {23'h0, c_eoi, c_eoi_vec},
              {23'h0, 1'b1, 8'h50});
        win_read(8'h14, 32'h0000_8050, "R10 level cleared");
        win_read(8'h16, 32'h0000_4050, "R10 edge kept");
        pulse_rirr(2);
        bus_write(8'h40, 32'h0000_0051);
        check(c_eoi && c_eoi_vec == 8'h51, "R10 pulse", {23'h0, c_eoi, c_eoi_vec},
              {23'h0, 1'b1, 8'h51});
        win_read(8'h14, 32'h0000_C050, "R10 other vector");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule